// File: doc/BRIEF.md
# Status Byte and Service Request Unit

This unit builds an 8-bit status byte from summary flags that the lower status groups supply. One of those flags is the event-summary flag. A host-programmable enable mask selects which of the byte's bits may request service. The unit keeps a latched request flag and drives an interrupt line from it.

The unit answers two kinds of read, and each returns the byte with a different meaning in bit 6.
- A serial poll returns the latched request flag in bit 6 and then clears that flag.
- A status query returns the live, unlatched master summary in bit 6 and changes nothing.

In both cases the other seven bits are the summary inputs as they stood in the cycle of the read. A read request is a one-cycle pulse. Its answer appears on `rd_data` with `rd_valid` in the following cycle.

The enable mask is written, read back and cleared through a simple register port. At reset the mask is cleared only when the power-on-clear flag is 1; otherwise it keeps its contents across the reset.

Top module: `status_srq_top`

## Requirements
- R1: The master summary is the OR of `sum_bits & mask` over all bits except bit 6, and it is not latched. A `query_req` pulse gives `rd_valid`=1 in the next cycle, with `rd_data` equal to the summary inputs of the request cycle and bit 6 replaced by the master summary of that cycle. When no read was requested in the previous cycle, `rd_valid`=0 and `rd_data`=0.
- R2: A rising edge of the master summary sets the request flag at the next clock edge. `irq` equals the request flag.
- R3: A `poll_req` pulse gives, in the next cycle, `rd_data` equal to the summary inputs of the request cycle with bit 6 replaced by the request flag of that cycle. The request flag is cleared at the same edge.
- R4: A status query leaves the request flag and the mask unchanged.
- R5: A master summary that stays at 1 does not set the request flag again after a poll has cleared it.
- R6: With a zero mask, the request flag is never set, whatever the summary inputs do.
- R7: `en_wr` loads `en_wdata` into the mask with bit 6 forced to 0. `en_clr` zeroes the mask and wins over `en_wr`. `en_rdata` always shows the mask.
- R8: Reset always clears the request flag and the read outputs. It clears the mask when `pon_clear`=1 and keeps the mask when `pon_clear`=0.
- R9: When `poll_req` and `query_req` arrive in the same cycle, the poll is served and the request flag is cleared.
- R10: When a summary rising edge and a poll arrive in the same cycle, the request flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pon_clear | input | 1 | Power-on-clear flag; clears the mask at reset when 1 |
| sum_bits | input | 8 | Summary flags from the lower groups; bit 6 is ignored |
| en_wr | input | 1 | Write strobe for the enable mask |
| en_wdata | input | 8 | Value to write into the enable mask |
| en_clr | input | 1 | Clear strobe for the enable mask |
| en_rdata | output | 8 | Current enable mask |
| poll_req | input | 1 | Serial poll request pulse |
| query_req | input | 1 | Status query request pulse |
| rd_valid | output | 1 | Read answer is valid |
| rd_data | output | 8 | Status byte answer |
| irq | output | 1 | Service request interrupt line |

## Verification
The bench targets the following corner cases, and each one exposes a specific kind of wrong design.
- **Poll versus query in bit 6.** A design that swapped the latched flag and the live summary in bit 6 would return the wrong bit in one read or the other.
- **Steady condition after a poll.** A level-triggered request would raise the interrupt again immediately after the poll cleared it.
- **Collisions.** A poll that arrives together with a query, or together with a new rising edge, would either serve the wrong read or lose the new request.
- **Mask edge cases.** A design that stored bit 6 of the mask, ignored the clear priority, or cleared the mask on every reset regardless of `pon_clear` shows up in `en_rdata` and `irq`.

// File: rtl/status_srq_pkg.sv
package status_srq_pkg;
    localparam int SB_W   = 8;
    localparam int RQ_POS = 6;

    typedef struct packed {
        logic [SB_W-1:0] mask;
    } mask_st_t;

    typedef struct packed {
        logic mss_prev;
        logic req;
    } req_st_t;

    typedef struct packed {
        logic            valid;
        logic [SB_W-1:0] data;
    } rd_st_t;
endpackage

// File: rtl/sb_mask_reg.sv
module sb_mask_reg
    import status_srq_pkg::*;
#(
    parameter int W  = SB_W,
    parameter int RQ = RQ_POS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pon_clear,
    input  logic         en_wr,
    input  logic [W-1:0] en_wdata,
    input  logic         en_clr,
    output logic [W-1:0] mask_o
);
    localparam logic [W-1:0] KEEP = ~(W'(1) << RQ);

    logic [W-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (en_clr)     mask_d = '0;
        else if (en_wr) mask_d = en_wdata & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            if (pon_clear) mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask_o = mask_q;

    // R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> (mask_q == '0));
    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_clr && !en_wr) |=> $stable(mask_q));
    // R7
    rq_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> !mask_q[RQ]);
endmodule

// File: rtl/sb_req_ctrl.sv
module sb_req_ctrl
    import status_srq_pkg::*;
#(
    parameter int W  = SB_W,
    parameter int RQ = RQ_POS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sum_bits,
    input  logic [W-1:0] mask,
    input  logic         poll_req,
    output logic         mss_o,
    output logic         req_o
);
    localparam logic [W-1:0] KEEP = ~(W'(1) << RQ);

    req_st_t st_d, st_q;
    logic    mss, rise;

    always_comb begin
        mss  = |(sum_bits & mask & KEEP);
        rise = mss && !st_q.mss_prev;
        st_d.mss_prev = mss;
        if (rise)          st_d.req = 1'b1;
        else if (poll_req) st_d.req = 1'b0;
        else               st_d.req = st_q.req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mss_o = mss;
    assign req_o = st_q.req;

    // R2
    set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.req) |-> ($past(mss) && !$past(st_q.mss_prev)));
    // R3
    poll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req && !rise) |=> !st_q.req);
    // R6
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> !$rose(st_q.req));
    // R10
    rise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && poll_req) |=> st_q.req);
endmodule

// File: rtl/sb_read_port.sv
module sb_read_port
    import status_srq_pkg::*;
#(
    parameter int W  = SB_W,
    parameter int RQ = RQ_POS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sum_bits,
    input  logic         poll_req,
    input  logic         query_req,
    input  logic         req_i,
    input  logic         mss_i,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    rd_st_t st_d, st_q;

    always_comb begin
        st_d.valid = poll_req || query_req;
        st_d.data  = '0;
        if (poll_req) begin
            st_d.data     = sum_bits;
            st_d.data[RQ] = req_i;
        end else if (query_req) begin
            st_d.data     = sum_bits;
            st_d.data[RQ] = mss_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.valid;
    assign rd_data  = st_q.data;

    // R1
    answer_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req || query_req) |=> rd_valid);
    // R9
    poll_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |=> (rd_data[RQ] == $past(req_i)));
    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_req && !query_req) |=> (rd_data == '0));
endmodule

// File: rtl/status_srq_top.sv
module status_srq_top
    import status_srq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pon_clear,
    input  logic [SB_W-1:0] sum_bits,
    input  logic            en_wr,
    input  logic [SB_W-1:0] en_wdata,
    input  logic            en_clr,
    output logic [SB_W-1:0] en_rdata,
    input  logic            poll_req,
    input  logic            query_req,
    output logic            rd_valid,
    output logic [SB_W-1:0] rd_data,
    output logic            irq
);
    logic [SB_W-1:0] mask;
    logic            mss, req;

    sb_mask_reg #(.W(SB_W), .RQ(RQ_POS)) u_mask (
        .clk(clk), .rst_n(rst_n), .pon_clear(pon_clear),
        .en_wr(en_wr), .en_wdata(en_wdata), .en_clr(en_clr),
        .mask_o(mask)
    );

    sb_req_ctrl #(.W(SB_W), .RQ(RQ_POS)) u_req (
        .clk(clk), .rst_n(rst_n), .sum_bits(sum_bits), .mask(mask),
        .poll_req(poll_req), .mss_o(mss), .req_o(req)
    );

    sb_read_port #(.W(SB_W), .RQ(RQ_POS)) u_rd (
        .clk(clk), .rst_n(rst_n), .sum_bits(sum_bits),
        .poll_req(poll_req), .query_req(query_req),
        .req_i(req), .mss_i(mss),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign en_rdata = mask;
    assign irq      = req;

    // R4
    query_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (query_req && !poll_req && !en_wr && !en_clr) |=> (!$past(irq) || irq) && $stable(en_rdata));
    // R2
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|en_rdata));
endmodule

// File: tb/status_srq_top_test.sv
module status_srq_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pon_clear = 1'b1;
    logic [7:0] sum_bits = '0;
    logic       en_wr = 1'b0;
    logic [7:0] en_wdata = '0;
    logic       en_clr = 1'b0;
    logic [7:0] en_rdata;
    logic       poll_req = 1'b0;
    logic       query_req = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       irq;

    int vectors = 0;
    int fails = 0;

    // reference state
    logic [7:0] m_mask = '0;
    logic       m_req = 0, m_prev = 0, m_rdv = 0;
    logic [7:0] m_rdata = '0;
    logic       m_last_poll = 0;

    always #2.5 clk = ~clk;

    status_srq_top uut (.*);

    initial begin
        #1000000;
        $display("FAIL watchdog expired");
        fails++;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R2 irq", {7'd0, irq}, {7'd0, m_req});
        check("R1 rd_valid", {7'd0, rd_valid}, {7'd0, m_rdv});
        check(m_last_poll ? "R3 rd_data" : "R1 rd_data", rd_data, m_rdata);
        check("R7 en_rdata", en_rdata, m_mask);
    endtask

    // one clock: model next state from inputs, then compare after the edge
    task automatic step();
        logic       mss, rise;
        logic [7:0] n_mask, n_rdata;
        logic       n_req;
        mss  = |(sum_bits & m_mask & 8'hBF);
        rise = mss && !m_prev;
        n_req = rise ? 1'b1 : (poll_req ? 1'b0 : m_req);
        n_rdata = 8'h00;
        if (poll_req)       n_rdata = {sum_bits[7], m_req, sum_bits[5:0]};
        else if (query_req) n_rdata = {sum_bits[7], mss, sum_bits[5:0]};
        n_mask = en_clr ? 8'h00 : (en_wr ? (en_wdata & 8'hBF) : m_mask);
        @(posedge clk);
        @(negedge clk);
        m_last_poll = poll_req;
        m_prev  = mss;
        m_req   = n_req;
        m_rdv   = poll_req || query_req;
        m_rdata = n_rdata;
        m_mask  = n_mask;
        compare_all();
    endtask

    task automatic idle();
        en_wr = 0; en_clr = 0; poll_req = 0; query_req = 0;
    endtask

    task automatic do_reset(input logic flag);
        pon_clear = flag;
        idle();
        rst_n = 0;
        m_req = 0; m_prev = 0; m_rdv = 0; m_rdata = '0; m_last_poll = 0;
        if (flag) m_mask = '0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R8
        compare_all();
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b1);
        check("R8 mask after reset", en_rdata, 8'h00);
        check("R8 irq after reset", {7'd0, irq}, 8'h00);

        // R7: bit 6 dropped on write
        idle(); en_wr = 1; en_wdata = 8'h41; step();
        check("R7 bit6 dropped", en_rdata, 8'h01);

        // R2: rising summary raises irq one edge later
        idle(); sum_bits = 8'h01; step();
        check("R2 irq set", {7'd0, irq}, 8'h01);

        // R1 / R4: query shows live summary, clears nothing
        query_req = 1; sum_bits = 8'h81; step();
        check("R1 query byte", rd_data, 8'hC1);
        check("R4 irq kept", {7'd0, irq}, 8'h01);

        // R3: poll returns latched flag and clears it
        idle(); poll_req = 1; step();
        check("R3 poll byte", rd_data, 8'hC1);
        check("R3 irq cleared", {7'd0, irq}, 8'h00);

        // R5: steady summary does not re-latch
        idle();
        for (int i = 0; i < 5; i++) step();
        check("R5 no relatch", {7'd0, irq}, 8'h00);
        query_req = 1; step();
        check("R1 live mss", rd_data, 8'hC1);
        idle(); poll_req = 1; step();
        check("R3 poll flag zero", rd_data, 8'h81);

        // R9: poll and query together
        idle(); sum_bits = 8'h00; step();
        sum_bits = 8'h01; step();
        poll_req = 1; query_req = 1; step();
        check("R9 poll served", rd_data, 8'h41);
        check("R9 irq cleared", {7'd0, irq}, 8'h00);

        // R10: rising edge together with poll
        idle(); sum_bits = 8'h00; step();
        sum_bits = 8'h01; poll_req = 1; step();
        check("R10 flag kept", {7'd0, irq}, 8'h01);
        idle(); poll_req = 1; step();

        // R7: clear wins over write
        idle(); en_wr = 1; en_wdata = 8'hFF; en_clr = 1; step();
        check("R7 clear priority", en_rdata, 8'h00);

        // R6: zero mask never requests
        idle();
        for (int i = 0; i < 20; i++) begin
            sum_bits = 8'(i * 37);
            step();
        end
        check("R6 no request", {7'd0, irq}, 8'h00);

        // R8: reset with flag 0 keeps mask
        idle(); en_wr = 1; en_wdata = 8'h24; step();
        do_reset(1'b0);
        check("R8 mask kept", en_rdata, 8'h24);
        do_reset(1'b1);
        check("R8 mask cleared", en_rdata, 8'h00);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            sum_bits  = (r[1:0] == 0) ? 8'($urandom) : sum_bits;
            en_wr     = ($urandom % 16) == 0;
            en_wdata  = 8'($urandom);
            en_clr    = ($urandom % 64) == 0;
            poll_req  = ($urandom % 5) == 0;
            query_req = ($urandom % 5) == 0;
            step();
        end
        idle();
        step();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule